// File: doc/BRIEF.md
# Debounced Input-Supply Undervoltage Qualifier

This block decides whether the input supply of a switching power stage is high enough to run. Once per oscillator period it asks a single question: did the PWM ramp reach its threshold (90% of full amplitude) before the oscillator tick arrived? A ramp that finishes early means the supply is high. A ramp that is still climbing when the tick comes means the supply is low. The ramp-threshold indication arrives as a digital flag. It is resynchronized, and its rising edge is held in a per-period latch. At every tick that latch is turned into one sample, good or low, and then cleared.

A two-state machine filters those samples. The states are ST_UNDER (undervoltage) and ST_GOOD (input good). In each state a small counter accumulates periods that disagree with the current state, and periods that agree leave the count unchanged. When the count reaches the filter length (seven by default, a 3-bit counter), the transition fires and the counter is cleared. The two transitions are UNDER_TO_GOOD, after seven good periods, and GOOD_TO_UNDER, after seven low periods. In ST_GOOD the block raises power-good and the soft-start enable. In ST_UNDER it holds both low and asserts the gate-drive disable.

Top module: `uvlo_qual`

## Requirements
- R1: In the cycle after reset the block is in ST_UNDER: `pgood_o`=0, `ss_en_o`=0 and `drv_off_o`=1.
- R2: A period counts as good only if `ramp_hit_i` rose during it, that is, between the previous `osc_tick_i` and this one. A period with no rise counts as a low period.
- R3: In ST_UNDER the seventh counted good period moves the block to ST_GOOD. The move is visible two cycles after the tick that ends that period, as `pgood_o`=1, `ss_en_o`=1 and `drv_off_o`=0, all changing in the same cycle.
- R4: In ST_UNDER, six counted good periods leave all outputs at their undervoltage values.
- R5: In ST_GOOD the seventh counted low period moves the block to ST_UNDER. In one cycle `pgood_o` and `ss_en_o` fall and `drv_off_o` rises.
- R6: The count is cumulative. A period that agrees with the current state neither advances nor clears it, so the disagreeing periods do not need to be consecutive.
- R7: The counter is cleared on every state change. The first opposite period after a transition therefore never moves the block back.
- R8: The outputs change only on a tick-derived sample, and a single opposite period never changes the state.
- R9: A ramp pulse that rises and falls again before the tick still makes that period good.
- R10: The latch is cleared at each tick. A rise in one period never makes the following period good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| osc_tick_i | input | 1 | One-cycle pulse that marks the end of an oscillator period |
| ramp_hit_i | input | 1 | Ramp reached its threshold (asynchronous, synchronized inside) |
| pgood_o | output | 1 | Input supply qualified good |
| ss_en_o | output | 1 | Soft-start enable |
| drv_off_o | output | 1 | Gate-drive disable, high in undervoltage |

## Verification
The bench drives whole oscillator periods of four kinds: periods with no ramp rise, periods where the flag rises and stays high until the tick, periods with a short pulse, and mixed sequences. Runs of exactly six and exactly seven good periods separate an off-by-one filter from a correct one. A low period placed right after good periods shows whether the latch is cleared at the tick. A good period mixed into a run of low periods separates a cumulative count from a consecutive one. A single good period right after entry to undervoltage shows whether the counter was cleared on the transition.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;

    typedef enum logic {
        ST_UNDER = 1'b0,
        ST_GOOD  = 1'b1
    } uvlo_state_e;

    function automatic int cnt_width(input int filt);
        return (filt > 2) ? $clog2(filt) : 1;
    endfunction

endpackage

// File: rtl/uvlo_sync.sv
module uvlo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[g] <= 1'b0;
                    else       chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[g] <= 1'b0;
                    else       chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uvlo_period_latch.sv
module uvlo_period_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic hit_s_i,
    output logic seen_o,
    output logic smp_vld_o,
    output logic smp_good_o
);
    logic hit_d_q;
    logic seen_q;
    logic vld_q;
    logic good_q;
    logic rise;

    assign rise = hit_s_i & ~hit_d_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hit_d_q <= 1'b0;
            seen_q  <= 1'b0;
            vld_q   <= 1'b0;
            good_q  <= 1'b0;
        end else begin
            hit_d_q <= hit_s_i;
            vld_q   <= tick_i;
            if (tick_i) begin
                good_q <= seen_q | rise;
                seen_q <= 1'b0;
            end else if (rise) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign seen_o     = seen_q;
    assign smp_vld_o  = vld_q;
    assign smp_good_o = good_q;
endmodule

// File: rtl/uvlo_filter_fsm.sv
module uvlo_filter_fsm
    import uvlo_pkg::*;
#(
    parameter int FILT_COUNT = 7,
    localparam int CNT_W = cnt_width(FILT_COUNT)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             smp_vld_i,
    input  logic             smp_good_i,
    output uvlo_state_e      state_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_COUNT - 1);

    uvlo_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             opposite;

    always_comb begin
        state_n  = state_q;
        cnt_n    = cnt_q;
        opposite = 1'b0;
        unique case (state_q)
            ST_UNDER: opposite = smp_vld_i &  smp_good_i;
            ST_GOOD:  opposite = smp_vld_i & ~smp_good_i;
        endcase
        if (opposite) begin
            if (cnt_q == LAST) begin
                cnt_n = '0;
                unique case (state_q)
                    ST_UNDER: state_n = ST_GOOD;
                    ST_GOOD:  state_n = ST_UNDER;
                endcase
            end else begin
                cnt_n = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_UNDER;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/uvlo_qual.sv
module uvlo_qual
    import uvlo_pkg::*;
#(
    parameter int FILT_COUNT  = 7,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = cnt_width(FILT_COUNT)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic osc_tick_i,
    input  logic ramp_hit_i,
    output logic pgood_o,
    output logic ss_en_o,
    output logic drv_off_o
);
    logic             hit_s;
    logic             seen;
    logic             smp_vld;
    logic             smp_good;
    uvlo_state_e      state;
    logic [CNT_W-1:0] cnt;

    uvlo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (ramp_hit_i),
        .q_o   (hit_s)
    );

    uvlo_period_latch u_latch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (osc_tick_i),
        .hit_s_i    (hit_s),
        .seen_o     (seen),
        .smp_vld_o  (smp_vld),
        .smp_good_o (smp_good)
    );

    uvlo_filter_fsm #(.FILT_COUNT(FILT_COUNT)) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .smp_vld_i  (smp_vld),
        .smp_good_i (smp_good),
        .state_o    (state),
        .cnt_o      (cnt)
    );

    always_comb begin
        unique case (state)
            ST_UNDER: begin
                pgood_o   = 1'b0;
                ss_en_o   = 1'b0;
                drv_off_o = 1'b1;
            end
            ST_GOOD: begin
                pgood_o   = 1'b1;
                ss_en_o   = 1'b1;
                drv_off_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/uvlo_qual_chk.sv
module uvlo_qual_chk #(
    parameter int FILT_COUNT = 7,
    parameter int CNT_W = 3
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             osc_tick_i,
    input logic             pgood_o,
    input logic             ss_en_o,
    input logic             drv_off_o,
    input logic             seen,
    input logic             smp_vld,
    input logic             smp_good,
    input logic [CNT_W-1:0] cnt
);
    AST_RISE_ON_GOOD_SAMPLE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pgood_o) |-> $past(smp_vld && smp_good)); // R3
    AST_FALL_ON_LOW_SAMPLE: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pgood_o) |-> $past(smp_vld && !smp_good)); // R5
    AST_HOLD_WITHOUT_SAMPLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(smp_vld) |-> $stable(pgood_o)); // R8
    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(cnt) < FILT_COUNT); // R6
    AST_CNT_CLEAR_ON_MOVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(pgood_o) |-> cnt == '0); // R7
    AST_OUTPUTS_TOGETHER: assert property (@(posedge clk_i) disable iff (rst_i)
        (ss_en_o == pgood_o) && (drv_off_o == !pgood_o)); // R5
    AST_LATCH_CLEARED: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(osc_tick_i) |-> !seen); // R10
endmodule

bind uvlo_qual uvlo_qual_chk #(.FILT_COUNT(FILT_COUNT), .CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .osc_tick_i (osc_tick_i),
    .pgood_o    (pgood_o),
    .ss_en_o    (ss_en_o),
    .drv_off_o  (drv_off_o),
    .seen       (seen),
    .smp_vld    (smp_vld),
    .smp_good   (smp_good),
    .cnt        (cnt)
);

// File: tb/uvlo_qual_tb.sv
module uvlo_qual_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PER_CYC    = 10;
    localparam int FILT       = 7;

    typedef struct {
        logic  pg;
        int    due;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic hit = 1'b0;
    logic pgood, ss_en, drv_off;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    logic m_good = 1'b0;
    int   m_cnt = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uvlo_qual u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .osc_tick_i (tick),
        .ramp_hit_i (hit),
        .pgood_o    (pgood),
        .ss_en_o    (ss_en),
        .drv_off_o  (drv_off)
    );

    task automatic check_out(input logic pg, input string tag);
        checks++;
        if (pgood !== pg || ss_en !== pg || drv_off !== !pg) begin
            errors++;
            $display("FAIL %s: pgood/ss_en/drv_off = %b%b%b expected %b%b%b",
                     tag, pgood, ss_en, drv_off, pg, pg, !pg);
        end
    endtask

    // mode: 0 no rise (low period), 1 rise and hold until tick, 2 short pulse
    task automatic run_period(input int mode, input string tag);
        exp_t e;
        logic good;
        for (int i = 0; i < PER_CYC - 1; i++) begin
            @(negedge clk);
            if (mode == 1 && i == 3) hit = 1'b1;
            if (mode == 2) hit = (i == 3 || i == 4);
        end
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        hit  = 1'b0;
        good = (mode != 0);
        if (good != m_good) begin
            if (m_cnt == FILT - 1) begin
                m_good = good;
                m_cnt  = 0;
            end else begin
                m_cnt++;
            end
        end
        e.pg  = m_good;
        e.due = cyc + 3;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                e = sb_q.pop_front();
                check_out(e.pg, e.tag);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_out(1'b0, "R1 reset state");

        run_period(0, "R2 no-rise period stays under");
        for (int k = 0; k < 6; k++) run_period(1, "R4 fewer than seven good periods");
        run_period(0, "R10 low period after good periods stays under");
        run_period(2, "R3 R9 seventh good period via short pulse");

        run_period(0, "R8 single low period keeps good");
        run_period(1, "R6 agreeing period keeps count");
        for (int k = 0; k < 4; k++) run_period(0, "R6 low periods accumulate");
        run_period(1, "R6 good period does not clear count");
        run_period(0, "R6 sixth low period still good");
        run_period(0, "R5 seventh low period drops to under");

        run_period(1, "R7 count cleared on entering under");
        for (int k = 0; k < 5; k++) run_period(2, "R7 still counting after clear");
        run_period(1, "R3 seventh good period after clear");
        run_period(0, "R7 count cleared on entering good");

        repeat (6) @(negedge clk);
        done = 1'b1;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule